// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records the system time at the start of a timing-protocol event packet, once for the transmit path and once for the receive path. Each direction has one 64-bit stamp slot, which software reads as a low word and a high word, and a valid flag. When a slot takes a stamp it locks. Later packets in that direction are not stamped until software reads the high word, so a held stamp always belongs to exactly one packet.

On transmit, the packet marks itself for stamping with a request flag. On receive, eligibility comes from header fields that an upstream parser has already extracted: whether the frame is layer 2 or UDP, its EtherType, its UDP destination port, the protocol version and the message-type byte. Two receive modes exist. The first is version 1 over UDP, where the message type must match a programmed code. The second is version 2 event mode, which covers both UDP and raw layer-2 frames. When the receive side takes a stamp, it raises a one-cycle descriptor status pulse so that the stamp can be tied to the received packet.

Top module: `ptp_stamp_latch`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, both valid flags are 0, both stamp words read 0 and `rx_desc_ts` is 0.
- R2: When `tx_sop` and `tx_ts_req` are high with `tx_en` high and the transmit slot unlocked, the slot stores the `sys_time` value present in that same cycle. `tx_valid` reads 1 from the next cycle.
- R3: No stamp is taken in a direction while its enable (`tx_en` or `rx_en`) is 0. A transmit packet with `tx_ts_req` low is not stamped.
- R4: While a slot's valid flag is 1, further eligible packets in that direction leave the stamp unchanged and cause no descriptor pulse.
- R5: Pulsing `rd_hi` for a locked slot clears its valid flag in the next cycle. After that, the next eligible packet is stamped.
- R6: With `rx_mode` = 0 (version 1 over UDP), a received packet is eligible only if `rx_is_udp` is 1, `rx_dst_port` equals `rx_ev_port`, `rx_version` is 1 and `rx_msg` equals `rx_v1_code`.
- R7: With `rx_mode` = 1 (version 2 event), a packet is eligible if `rx_version` is 2 and the low nibble of `rx_msg` is 0 to 3 (this range includes the path-delay types 2 and 3). `rx_v1_code` plays no part. The packet must also arrive over UDP on `rx_ev_port` or as a qualifying layer-2 frame. Low nibbles of 4 or more are not stamped.
- R8: A layer-2 frame (`rx_is_l2` = 1) qualifies in mode 1 only if `etf_en` and `etf_ts` are both 1, `etf_type` is 0x88F7 and `rx_ethertype` equals 0x88F7.
- R9: `rx_desc_ts` pulses high for exactly one cycle, in the first cycle that `rx_valid` reads 1 after a receive capture.
- R10: The two directions are independent. Captures and reads in one direction do not change the other direction's stamp or flag, and both can capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | 64 | Running system time counter |
| tx_en | input | 1 | Transmit stamping enable |
| tx_sop | input | 1 | Transmit start-of-packet strobe |
| tx_ts_req | input | 1 | Transmit packet requests a stamp |
| tx_rd_hi | input | 1 | Read strobe of transmit stamp high word (unlocks) |
| tx_valid | output | 1 | Transmit stamp held |
| tx_stamp_lo | output | 32 | Transmit stamp low word |
| tx_stamp_hi | output | 32 | Transmit stamp high word |
| rx_en | input | 1 | Receive stamping enable |
| rx_mode | input | 1 | 0: version 1 over UDP, 1: version 2 event |
| rx_ev_port | input | 16 | Event UDP port to match |
| rx_v1_code | input | 8 | Version 1 message-type code |
| etf_en | input | 1 | EtherType filter entry enabled |
| etf_ts | input | 1 | EtherType filter entry requests stamping |
| etf_type | input | 16 | EtherType filter value |
| rx_sop | input | 1 | Receive start-of-packet strobe |
| rx_is_l2 | input | 1 | Received frame carries the protocol directly over layer 2 |
| rx_ethertype | input | 16 | Received frame EtherType |
| rx_is_udp | input | 1 | Received frame is UDP |
| rx_dst_port | input | 16 | Received UDP destination port |
| rx_version | input | 4 | Received protocol version |
| rx_msg | input | 8 | Received message-type byte |
| rx_rd_hi | input | 1 | Read strobe of receive stamp high word (unlocks) |
| rx_valid | output | 1 | Receive stamp held |
| rx_stamp_lo | output | 32 | Receive stamp low word |
| rx_stamp_hi | output | 32 | Receive stamp high word |
| rx_desc_ts | output | 1 | One-cycle descriptor timestamp status |

## Verification
Some properties are checked on every cycle. A valid flag rises only after a start strobe in an enabled direction, and the stamp then equals the time of that strobe cycle. A locked stamp stays frozen, and a high-word read unlocks the slot. The descriptor pulse matches each rising edge of the receive valid flag. The receive eligibility rules can only be shown by the bench's scenarios: mode selection, port and code matching, the path-delay types, the EtherType entry conditions and the simultaneous capture in both directions. Each scenario compares the expected stamps and verifies that the non-matching packets leave the slot empty.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

    localparam int PORT_W  = 16;
    localparam int ETYPE_W = 16;
    localparam int MSG_W   = 8;
    localparam int VER_W   = 4;

    localparam logic [ETYPE_W-1:0] PTP_ETYPE = 16'h88F7;
    localparam logic [VER_W-1:0]   VER_ONE   = 4'd1;
    localparam logic [VER_W-1:0]   VER_TWO   = 4'd2;

    typedef enum logic {
        MODE_V1_UDP   = 1'b0,
        MODE_V2_EVENT = 1'b1
    } rx_mode_e;

    typedef struct packed {
        logic               is_l2;
        logic [ETYPE_W-1:0] ethertype;
        logic               is_udp;
        logic [PORT_W-1:0]  dst_port;
        logic [VER_W-1:0]   version;
        logic [MSG_W-1:0]   msg;
    } rx_hdr_t;

    typedef struct packed {
        rx_mode_e           mode;
        logic [PORT_W-1:0]  ev_port;
        logic [MSG_W-1:0]   v1_code;
        logic               etf_en;
        logic               etf_ts;
        logic [ETYPE_W-1:0] etf_type;
    } rx_cfg_t;

    // Version 2 event messages carry type 0..3 in the low nibble.
    function automatic logic v2_event_type(input logic [MSG_W-1:0] m);
        return (m[3:2] == 2'b00);
    endfunction

endpackage

// File: rtl/ptp_rx_filter.sv
module ptp_rx_filter
    import ptp_stamp_pkg::*;
(
    input  rx_cfg_t cfg,
    input  rx_hdr_t hdr,
    output logic    eligible
);

    logic udp_hit;
    logic l2_entry_ok;
    logic l2_hit;
    logic v1_ok;
    logic v2_ok;

    always_comb begin
        udp_hit     = hdr.is_udp && (hdr.dst_port == cfg.ev_port);
        l2_entry_ok = cfg.etf_en && cfg.etf_ts && (cfg.etf_type == PTP_ETYPE);
        l2_hit      = hdr.is_l2 && l2_entry_ok && (hdr.ethertype == cfg.etf_type);
        v1_ok       = (cfg.mode == MODE_V1_UDP) && udp_hit &&
                      (hdr.version == VER_ONE) && (hdr.msg == cfg.v1_code);
        v2_ok       = (cfg.mode == MODE_V2_EVENT) && (hdr.version == VER_TWO) &&
                      v2_event_type(hdr.msg) && (udp_hit || l2_hit);
        eligible    = v1_ok || v2_ok;
    end

endmodule

// File: rtl/ptp_stamp_slot.sv
module ptp_stamp_slot #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              hit,
    input  logic              rd_hi,
    input  logic [TIME_W-1:0] now,
    output logic [TIME_W-1:0] stamp,
    output logic              valid,
    output logic              took
);

    logic capture;

    always_comb capture = en && hit && !valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp <= '0;
            valid <= 1'b0;
            took  <= 1'b0;
        end else begin
            took <= capture;
            if (capture) begin
                stamp <= now;
                valid <= 1'b1;
            end else if (rd_hi) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ptp_stamp_latch.sv
module ptp_stamp_latch
    import ptp_stamp_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TIME_W-1:0]   sys_time,
    input  logic                tx_en,
    input  logic                tx_sop,
    input  logic                tx_ts_req,
    input  logic                tx_rd_hi,
    output logic                tx_valid,
    output logic [TIME_W/2-1:0] tx_stamp_lo,
    output logic [TIME_W/2-1:0] tx_stamp_hi,
    input  logic                rx_en,
    input  logic                rx_mode,
    input  logic [15:0]         rx_ev_port,
    input  logic [7:0]          rx_v1_code,
    input  logic                etf_en,
    input  logic                etf_ts,
    input  logic [15:0]         etf_type,
    input  logic                rx_sop,
    input  logic                rx_is_l2,
    input  logic [15:0]         rx_ethertype,
    input  logic                rx_is_udp,
    input  logic [15:0]         rx_dst_port,
    input  logic [3:0]          rx_version,
    input  logic [7:0]          rx_msg,
    input  logic                rx_rd_hi,
    output logic                rx_valid,
    output logic [TIME_W/2-1:0] rx_stamp_lo,
    output logic [TIME_W/2-1:0] rx_stamp_hi,
    output logic                rx_desc_ts
);

    localparam int HALF_W = TIME_W / 2;
    localparam int N_DIR  = 2;
    localparam int D_TX   = 0;
    localparam int D_RX   = 1;

    rx_cfg_t rcfg;
    rx_hdr_t rhdr;
    logic    rx_elig;

    always_comb begin
        rcfg.mode      = rx_mode_e'(rx_mode);
        rcfg.ev_port   = rx_ev_port;
        rcfg.v1_code   = rx_v1_code;
        rcfg.etf_en    = etf_en;
        rcfg.etf_ts    = etf_ts;
        rcfg.etf_type  = etf_type;
        rhdr.is_l2     = rx_is_l2;
        rhdr.ethertype = rx_ethertype;
        rhdr.is_udp    = rx_is_udp;
        rhdr.dst_port  = rx_dst_port;
        rhdr.version   = rx_version;
        rhdr.msg       = rx_msg;
    end

    ptp_rx_filter u_filter (
        .cfg      (rcfg),
        .hdr      (rhdr),
        .eligible (rx_elig)
    );

    logic [N_DIR-1:0]  d_en;
    logic [N_DIR-1:0]  d_hit;
    logic [N_DIR-1:0]  d_rd;
    logic [N_DIR-1:0]  d_valid;
    logic [N_DIR-1:0]  d_took;
    logic [TIME_W-1:0] d_stamp [N_DIR];

    always_comb begin
        d_en[D_TX]  = tx_en;
        d_hit[D_TX] = tx_sop && tx_ts_req;
        d_rd[D_TX]  = tx_rd_hi;
        d_en[D_RX]  = rx_en;
        d_hit[D_RX] = rx_sop && rx_elig;
        d_rd[D_RX]  = rx_rd_hi;
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        ptp_stamp_slot #(.TIME_W(TIME_W)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .en    (d_en[d]),
            .hit   (d_hit[d]),
            .rd_hi (d_rd[d]),
            .now   (sys_time),
            .stamp (d_stamp[d]),
            .valid (d_valid[d]),
            .took  (d_took[d])
        );
    end

    assign tx_valid    = d_valid[D_TX];
    assign tx_stamp_lo = d_stamp[D_TX][HALF_W-1:0];
    assign tx_stamp_hi = d_stamp[D_TX][TIME_W-1:HALF_W];
    assign rx_valid    = d_valid[D_RX];
    assign rx_stamp_lo = d_stamp[D_RX][HALF_W-1:0];
    assign rx_stamp_hi = d_stamp[D_RX][TIME_W-1:HALF_W];
    assign rx_desc_ts  = d_took[D_RX];

endmodule

// File: rtl/ptp_stamp_latch_chk.sv
module ptp_stamp_latch_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [2*W-1:0] sys_time,
    input logic         tx_en,
    input logic         tx_sop,
    input logic         tx_ts_req,
    input logic         tx_rd_hi,
    input logic         tx_valid,
    input logic [W-1:0] tx_stamp_lo,
    input logic [W-1:0] tx_stamp_hi,
    input logic         rx_en,
    input logic         rx_sop,
    input logic         rx_rd_hi,
    input logic         rx_valid,
    input logic [W-1:0] rx_stamp_lo,
    input logic [W-1:0] rx_stamp_hi,
    input logic         rx_desc_ts
);

    AST_TX_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(tx_sop && tx_ts_req && tx_en)); // R2
    AST_TX_STAMP_TIME: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> ({tx_stamp_hi, tx_stamp_lo} == $past(sys_time))); // R2
    AST_RX_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(rx_sop && rx_en)); // R3
    AST_TX_OFF: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !tx_valid) |=> !tx_valid); // R3
    AST_TX_LOCK: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && $past(tx_valid)) |-> $stable({tx_stamp_hi, tx_stamp_lo})); // R4
    AST_RX_LOCK: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && $past(rx_valid)) |-> $stable({rx_stamp_hi, rx_stamp_lo})); // R4
    AST_TX_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_rd_hi) |=> !tx_valid); // R5
    AST_RX_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_rd_hi) |=> !rx_valid); // R5
    AST_RX_TAG_EDGE: assert property (@(posedge clk) disable iff (rst)
        rx_desc_ts == $rose(rx_valid)); // R9

endmodule

bind ptp_stamp_latch ptp_stamp_latch_chk #(.W(TIME_W/2)) u_chk (.*);

// File: tb/ptp_stamp_latch_tb.sv
module ptp_stamp_latch_tb;

    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] sys_time = 64'h1234_5678_9ABC_0000;
    logic        tx_en = 0, tx_sop = 0, tx_ts_req = 0, tx_rd_hi = 0;
    logic        tx_valid;
    logic [31:0] tx_stamp_lo, tx_stamp_hi;
    logic        rx_en = 0, rx_mode = 0;
    logic [15:0] rx_ev_port = 16'd319;
    logic [7:0]  rx_v1_code = 8'h00;
    logic        etf_en = 0, etf_ts = 0;
    logic [15:0] etf_type = 16'h0;
    logic        rx_sop = 0, rx_is_l2 = 0, rx_is_udp = 0;
    logic [15:0] rx_ethertype = 0, rx_dst_port = 0;
    logic [3:0]  rx_version = 0;
    logic [7:0]  rx_msg = 0;
    logic        rx_rd_hi = 0;
    logic        rx_valid;
    logic [31:0] rx_stamp_lo, rx_stamp_hi;
    logic        rx_desc_ts;

    always #(CLK_P/2) clk = ~clk;

    ptp_stamp_latch u_dut (.*);

    int checks = 0;
    int bad = 0;
    int tag_cnt = 0;
    logic [63:0] tx_q[$];
    logic [63:0] rx_q[$];
    logic tx_prev = 0, rx_prev = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        sys_time = sys_time + 64'd7;
        tx_sop = 0; rx_sop = 0; tx_rd_hi = 0; rx_rd_hi = 0;
    endtask

    task automatic send_tx(input bit req, input bit expect_cap);
        step();
        tx_sop = 1; tx_ts_req = req;
        if (expect_cap) tx_q.push_back(sys_time);
        step(); step();
    endtask

    task automatic send_rx(input bit l2, input logic [15:0] et, input bit udp,
                           input logic [15:0] port, input logic [3:0] ver,
                           input logic [7:0] msg, input bit expect_cap);
        step();
        rx_sop = 1; rx_is_l2 = l2; rx_ethertype = et; rx_is_udp = udp;
        rx_dst_port = port; rx_version = ver; rx_msg = msg;
        if (expect_cap) rx_q.push_back(sys_time);
        step(); step();
    endtask

    task automatic read_tx();
        step(); tx_rd_hi = 1; step();
    endtask

    task automatic read_rx();
        step(); rx_rd_hi = 1; step();
    endtask

    // Monitor: pops the expected stamp on every rising valid flag.
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_valid && !tx_prev) begin
                if (tx_q.size() == 0) chk(0, "R2 unexpected tx stamp", {tx_stamp_hi, tx_stamp_lo}, 64'h0);
                else begin
                    logic [63:0] e;
                    e = tx_q.pop_front();
                    chk({tx_stamp_hi, tx_stamp_lo} == e, "R2 tx stamp", {tx_stamp_hi, tx_stamp_lo}, e);
                end
            end
            if (rx_valid && !rx_prev) begin
                chk(rx_desc_ts == 1'b1, "R9 tag with valid rise", {63'h0, rx_desc_ts}, 64'h1);
                if (rx_q.size() == 0) chk(0, "R6 unexpected rx stamp", {rx_stamp_hi, rx_stamp_lo}, 64'h0);
                else begin
                    logic [63:0] e;
                    e = rx_q.pop_front();
                    chk({rx_stamp_hi, rx_stamp_lo} == e, "R6 rx stamp", {rx_stamp_hi, rx_stamp_lo}, e);
                end
            end
            if (rx_desc_ts) tag_cnt++;
            tx_prev = tx_valid;
            rx_prev = rx_valid;
        end
    end

    initial begin
        #(CLK_P * 20000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [63:0] held;
        int tags_before;
        repeat (3) step();
        chk(tx_valid == 0 && rx_valid == 0 && rx_desc_ts == 0, "R1 flags in reset",
            {61'h0, tx_valid, rx_valid, rx_desc_ts}, 64'h0);
        rst = 0;
        step();
        chk({tx_stamp_hi, tx_stamp_lo, rx_stamp_hi, rx_stamp_lo} == 0 && !tx_valid && !rx_valid,
            "R1 after reset", {tx_stamp_hi, tx_stamp_lo}, 64'h0);

        // Transmit path
        tx_en = 1;
        send_tx(1, 1);
        chk(tx_valid == 1, "R2 tx valid set", {63'h0, tx_valid}, 64'h1);
        held = {tx_stamp_hi, tx_stamp_lo};
        send_tx(1, 0);
        chk({tx_stamp_hi, tx_stamp_lo} == held && tx_valid, "R4 tx locked", {tx_stamp_hi, tx_stamp_lo}, held);
        read_tx();
        chk(tx_valid == 0, "R5 tx read clears", {63'h0, tx_valid}, 64'h0);
        send_tx(0, 0);
        chk(tx_valid == 0, "R3 tx no request", {63'h0, tx_valid}, 64'h0);
        tx_en = 0;
        send_tx(1, 0);
        chk(tx_valid == 0, "R3 tx disabled", {63'h0, tx_valid}, 64'h0);
        tx_en = 1;
        send_tx(1, 1);
        chk(tx_valid == 1, "R5 tx restamps after read", {63'h0, tx_valid}, 64'h1);
        read_tx();

        // Receive, version 1 over UDP
        rx_en = 1; rx_mode = 0; rx_v1_code = 8'h01;
        send_rx(0, 16'h0800, 1, 16'd319, 4'd1, 8'h01, 1);
        chk(rx_valid == 1, "R6 v1 match", {63'h0, rx_valid}, 64'h1);
        held = {rx_stamp_hi, rx_stamp_lo};
        tags_before = tag_cnt;
        send_rx(0, 16'h0800, 1, 16'd319, 4'd1, 8'h01, 0);
        chk({rx_stamp_hi, rx_stamp_lo} == held, "R4 rx locked", {rx_stamp_hi, rx_stamp_lo}, held);
        chk(tag_cnt == tags_before, "R4 no tag while locked", tag_cnt, tags_before);
        read_rx();
        chk(rx_valid == 0, "R5 rx read clears", {63'h0, rx_valid}, 64'h0);
        send_rx(0, 16'h0800, 1, 16'd319, 4'd1, 8'h00, 0);
        chk(rx_valid == 0, "R6 v1 wrong code", {63'h0, rx_valid}, 64'h0);
        send_rx(0, 16'h0800, 1, 16'd320, 4'd1, 8'h01, 0);
        chk(rx_valid == 0, "R6 v1 wrong port", {63'h0, rx_valid}, 64'h0);
        send_rx(0, 16'h0800, 1, 16'd319, 4'd2, 8'h01, 0);
        chk(rx_valid == 0, "R6 v2 packet in v1 mode", {63'h0, rx_valid}, 64'h0);

        // Receive, version 2 event
        rx_mode = 1; rx_v1_code = 8'h00;
        send_rx(0, 16'h0800, 1, 16'd319, 4'd2, 8'h02, 1);
        chk(rx_valid == 1, "R7 path delay stamped", {63'h0, rx_valid}, 64'h1);
        read_rx();
        send_rx(0, 16'h0800, 1, 16'd319, 4'd2, 8'h08, 0);
        chk(rx_valid == 0, "R7 general message ignored", {63'h0, rx_valid}, 64'h0);
        send_rx(1, 16'h88F7, 0, 16'd0, 4'd2, 8'h00, 0);
        chk(rx_valid == 0, "R8 l2 without filter entry", {63'h0, rx_valid}, 64'h0);
        etf_en = 1; etf_ts = 0; etf_type = 16'h88F7;
        send_rx(1, 16'h88F7, 0, 16'd0, 4'd2, 8'h00, 0);
        chk(rx_valid == 0, "R8 l2 entry without stamp bit", {63'h0, rx_valid}, 64'h0);
        etf_ts = 1;
        send_rx(1, 16'h88F7, 0, 16'd0, 4'd2, 8'h03, 1);
        chk(rx_valid == 1, "R8 l2 stamped", {63'h0, rx_valid}, 64'h1);
        read_rx();

        // Independence: both directions in one cycle
        step();
        tx_sop = 1; tx_ts_req = 1;
        rx_sop = 1; rx_is_l2 = 0; rx_is_udp = 1; rx_dst_port = 16'd319;
        rx_version = 4'd2; rx_msg = 8'h01;
        tx_q.push_back(sys_time); rx_q.push_back(sys_time);
        step(); step();
        held = {tx_stamp_hi, tx_stamp_lo};
        read_rx();
        chk(tx_valid == 1 && {tx_stamp_hi, tx_stamp_lo} == held, "R10 rx read keeps tx",
            {tx_stamp_hi, tx_stamp_lo}, held);
        read_tx();

        rx_en = 0;
        send_rx(0, 16'h0800, 1, 16'd319, 4'd2, 8'h00, 0);
        chk(rx_valid == 0, "R3 rx disabled", {63'h0, rx_valid}, 64'h0);

        step(); step();
        chk(tx_q.size() == 0 && rx_q.size() == 0, "R2 all expected stamps seen",
            tx_q.size() + rx_q.size(), 64'h0);
        chk(tag_cnt == 4, "R9 tag count", tag_cnt, 64'd4);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule